// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives words on a single data line while driving the shift clock itself. It acts as the clock master of a half-duplex synchronous link: when receiving is allowed, it toggles the clock pin at a programmed rate and captures one data bit each time the clock returns to its idle level. Words are 8 or 9 bits long, least significant bit first. Completed words go into a two-entry holding buffer, which the host drains one word per read strobe.

There are two ways to start receiving. A one-shot request takes exactly one word and then clears itself. A continuous enable takes words back to back for as long as it stays high, and it wins when both are active. If a word completes while the buffer is full, that word is dropped. An overrun flag is then raised, and it halts the clock until the host lowers the continuous enable. The clock rate comes from a divider built from a high and a low byte, used either as a 16-bit value or as the low byte alone.

Top module: `sync_rx_master`

## Requirements
- R1: Clocking runs only while port_en, sync_master and (cont_en or single_busy) are all high and overrun is low. In any cycle where this is false, the clock returns to its idle level and a partly received word is discarded.
- R2: Bits are assembled least significant bit first: the k-th sample of a word becomes bit k. Each finished word enters a two-entry FIFO. rx_ready is high while the FIFO holds a word, and rx_data and rx_bit9 show the oldest word. A cycle with rd_pop high and rx_ready high removes that word.
- R3: A one-cycle pulse on single_req sets single_busy. single_busy clears at the clock edge that completes a word. If single_req is high in that same cycle, single_busy stays set.
- R4: With cont_en high, words follow one another with no gap. With both cont_en and single_busy high, reception goes on past the first word even though single_busy has cleared.
- R5: For a divider value D, every bit lasts 2*(D+1) cycles: D+1 cycles at the idle level, then D+1 cycles at the active level. The data line is sampled at the edge where the clock returns to idle.
- R6: The clock idles low when clk_inv is 0 and idles high when clk_inv is 1.
- R7: When rx9_en is 1, a word has nine samples and the ninth appears on rx_bit9. When rx9_en is 0, a word has eight samples and rx_bit9 reads 0 for that word.
- R8: irq equals rx_ready AND irq_en.
- R9: A word that completes while the FIFO holds two words and no pop happens in that cycle is dropped, and overrun rises. overrun stays high until a cycle in which cont_en is low, and it blocks clocking as stated in R1.
- R10: With div_wide = 1, D is {div_hi, div_lo}. With div_wide = 0, D is div_lo alone and div_hi has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Serial port enable |
| sync_master | input | 1 | Selects synchronous master operation |
| cont_en | input | 1 | Continuous receive enable (level) |
| single_req | input | 1 | One-cycle pulse that requests one word |
| rx9_en | input | 1 | Selects 9-bit words |
| clk_inv | input | 1 | Clock idle level: 0 low, 1 high |
| div_wide | input | 1 | Selects 16-bit divider operation |
| div_hi | input | 8 | Divider high byte |
| div_lo | input | 8 | Divider low byte |
| irq_en | input | 1 | Receive interrupt enable |
| rd_pop | input | 1 | Read strobe that pops the oldest word |
| data_in | input | 1 | Serial data line |
| sclk_out | output | 1 | Generated shift clock |
| single_busy | output | 1 | One-shot request pending |
| rx_ready | output | 1 | Receive-complete flag (FIFO not empty) |
| rx_data | output | 8 | Low eight bits of the oldest word |
| rx_bit9 | output | 1 | Ninth bit of the oldest word |
| overrun | output | 1 | Overrun error flag |
| irq | output | 1 | Receive interrupt |

## Verification
Any fault in the half-period counter or the phase register shows up on sclk_out at the very next edge it gets wrong, because the bench predicts the clock level in every cycle. A wrong bit index or a wrong sample point goes unseen until the word completes. It then shows up as a wrong rx_data or rx_bit9 value, at most one word time later. Faults in the FIFO count, the one-shot bit or the overrun bit show up on rx_ready, single_busy, overrun or irq in the cycle after the edge where they go wrong. A drop that should not happen, or a missed overrun, appears as a count of stored words that differs from the model.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;

    localparam int DATA_W = 8;
    localparam int WORD_W = DATA_W + 1;
    localparam int DIV_W  = 16;

    typedef struct packed {
        logic              b9;
        logic [DATA_W-1:0] data;
    } rx_word_t;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_ACTIVE = 1'b1
    } clk_phase_e;

    function automatic logic [DIV_W-1:0] pick_divider(
        input logic       wide,
        input logic [7:0] hi,
        input logic [7:0] lo
    );
        return wide ? {hi, lo} : {8'h00, lo};
    endfunction

endpackage

// File: rtl/sync_rx_baud.sv
module sync_rx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div_val);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_cnt_reset_R1: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/sync_rx_shifter.sv
module sync_rx_shifter
    import sync_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick,
    input  logic              wide_word,
    input  logic              din,
    output clk_phase_e        phase_o,
    output logic              done_o,
    output logic [DATA_W:0]   word_o
);
    localparam int BITS  = DATA_W + 1;
    localparam int IDX_W = $clog2(BITS);
    localparam logic [IDX_W-1:0] LAST_WIDE   = IDX_W'(BITS - 1);
    localparam logic [IDX_W-1:0] LAST_NARROW = IDX_W'(BITS - 2);

    clk_phase_e       phase_q;
    logic [IDX_W-1:0] idx_q;
    logic [BITS-1:0]  shreg_q;
    logic [BITS-1:0]  merged;
    logic [IDX_W-1:0] last_idx;
    logic             sample;

    assign last_idx = wide_word ? LAST_WIDE : LAST_NARROW;
    assign sample   = tick && (phase_q == PH_ACTIVE);

    always_comb begin
        merged        = shreg_q;
        merged[idx_q] = din;
    end

    assign done_o  = sample && (idx_q == last_idx);
    assign word_o  = merged;
    assign phase_o = phase_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            shreg_q <= '0;
        end else if (tick) begin
            if (phase_q == PH_IDLE) begin
                phase_q <= PH_ACTIVE;
            end else begin
                phase_q <= PH_IDLE;
                if (idx_q == last_idx) begin
                    idx_q   <= '0;
                    shreg_q <= '0;
                end else begin
                    idx_q   <= idx_q + 1'b1;
                    shreg_q <= merged;
                end
            end
        end
    end

    assert_idle_when_stopped_R1: assert property (@(posedge clk) disable iff (rst)
        !run |=> (phase_q == PH_IDLE));

    assert_sample_on_return_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (phase_q == PH_IDLE) && (idx_q == '0));

endmodule

// File: rtl/sync_rx_fifo.sv
module sync_rx_fifo #(
    parameter int DEPTH = 2,
    parameter int W     = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop_req,
    output logic [W-1:0] head,
    output logic         not_empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [CNT_W-1:0] count_q;
    logic             pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign not_empty = (count_q != '0);
    assign full      = (count_q == CNT_W'(DEPTH));
    assign pop       = pop_req && not_empty;
    assign head      = mem_q[rd_q];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[g] <= '0;
            end else if (push && wr_q == PTR_W'(g)) begin
                mem_q[g] <= din;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q    <= '0;
            wr_q    <= '0;
            count_q <= '0;
        end else begin
            if (push) wr_q <= bump(wr_q);
            if (pop)  rd_q <= bump(rd_q);
            case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        push |-> (!full || pop));

    assert_count_range_R2: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/sync_rx_master.sv
module sync_rx_master
    import sync_rx_pkg::*;
#(
    parameter int FIFO_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       port_en,
    input  logic       sync_master,
    input  logic       cont_en,
    input  logic       single_req,
    input  logic       rx9_en,
    input  logic       clk_inv,
    input  logic       div_wide,
    input  logic [7:0] div_hi,
    input  logic [7:0] div_lo,
    input  logic       irq_en,
    input  logic       rd_pop,
    input  logic       data_in,
    output logic       sclk_out,
    output logic       single_busy,
    output logic       rx_ready,
    output logic [7:0] rx_data,
    output logic       rx_bit9,
    output logic       overrun,
    output logic       irq
);
    logic             single_q;
    logic             overrun_q;
    logic             run;
    logic             tick;
    logic [DIV_W-1:0] div_val;
    clk_phase_e       phase;
    logic             word_done;
    logic [DATA_W:0]  word_bits;
    rx_word_t         word_in;
    rx_word_t         word_head;
    logic             fifo_full;
    logic             pop_fire;
    logic             can_store;
    logic             push;
    logic             ovr_set;

    assign div_val = pick_divider(div_wide, div_hi, div_lo);
    assign run     = port_en && sync_master && (cont_en || single_q) && !overrun_q;

    sync_rx_baud #(.DIV_W(DIV_W)) baud_i (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .div_val (div_val),
        .tick    (tick)
    );

    sync_rx_shifter #(.DATA_W(DATA_W)) shift_i (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .tick      (tick),
        .wide_word (rx9_en),
        .din       (data_in),
        .phase_o   (phase),
        .done_o    (word_done),
        .word_o    (word_bits)
    );

    assign word_in   = rx_word_t'(word_bits);
    assign pop_fire  = rd_pop && rx_ready;
    assign can_store = !fifo_full || pop_fire;
    assign push      = word_done && can_store;
    assign ovr_set   = word_done && !can_store;

    sync_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) fifo_i (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .din       (word_in),
        .pop_req   (rd_pop),
        .head      (word_head),
        .not_empty (rx_ready),
        .full      (fifo_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            single_q <= 1'b0;
        end else if (single_req) begin
            single_q <= 1'b1;
        end else if (word_done) begin
            single_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            overrun_q <= 1'b0;
        end else if (ovr_set) begin
            overrun_q <= 1'b1;
        end else if (!cont_en) begin
            overrun_q <= 1'b0;
        end
    end

    assign sclk_out    = (phase == PH_ACTIVE) ^ clk_inv;
    assign single_busy = single_q;
    assign rx_data     = word_head.data;
    assign rx_bit9     = word_head.b9;
    assign overrun     = overrun_q;
    assign irq         = rx_ready && irq_en;

    assert_single_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (word_done && !single_req) |=> !single_q);

    assert_overrun_halts_R9: assert property (@(posedge clk) disable iff (rst)
        overrun_q |=> !word_done);

    assert_overrun_release_R9: assert property (@(posedge clk) disable iff (rst)
        (!cont_en && !word_done) |=> !overrun_q);

endmodule

// File: tb/sync_rx_master_tb_top.sv
module sync_rx_master_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       port_en = 1'b0, sync_master = 1'b0, cont_en = 1'b0, single_req = 1'b0;
    logic       rx9_en = 1'b0, clk_inv = 1'b0, div_wide = 1'b0, irq_en = 1'b0;
    logic [7:0] div_hi = 8'h00, div_lo = 8'h00;
    logic       rd_pop = 1'b0, data_in = 1'b0;
    logic       sclk_out, single_busy, rx_ready, rx_bit9, overrun, irq;
    logic [7:0] rx_data;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    sync_rx_master dut_i (
        .clk(clk), .rst(rst), .port_en(port_en), .sync_master(sync_master),
        .cont_en(cont_en), .single_req(single_req), .rx9_en(rx9_en),
        .clk_inv(clk_inv), .div_wide(div_wide), .div_hi(div_hi), .div_lo(div_lo),
        .irq_en(irq_en), .rd_pop(rd_pop), .data_in(data_in),
        .sclk_out(sclk_out), .single_busy(single_busy), .rx_ready(rx_ready),
        .rx_data(rx_data), .rx_bit9(rx_bit9), .overrun(overrun), .irq(irq)
    );

    always #5 clk = ~clk;

    // ---------------- behavioural reference ----------------
    int         m_cnt, m_idx;
    bit         m_phase, m_single, m_ovr;
    bit  [8:0]  m_sh;
    bit  [8:0]  m_q[$];

    always @(posedge clk) begin
        int  d;
        bit  go, fin, popped;
        bit  [8:0] w;
        if (rst) begin
            m_cnt = 0; m_idx = 0; m_phase = 0; m_single = 0; m_ovr = 0; m_sh = '0;
            m_q.delete();
        end else begin
            d   = div_wide ? int'({div_hi, div_lo}) : int'(div_lo);
            go  = port_en && sync_master && (cont_en || m_single) && !m_ovr;
            fin = 0;
            w   = '0;
            if (!go) begin
                m_cnt = 0; m_phase = 0; m_idx = 0; m_sh = '0;
            end else if (m_cnt == d) begin
                m_cnt = 0;
                if (!m_phase) begin
                    m_phase = 1;
                end else begin
                    m_phase = 0;
                    m_sh[m_idx] = data_in;
                    if (m_idx == (rx9_en ? 8 : 7)) begin
                        fin = 1; w = m_sh; m_idx = 0; m_sh = '0;
                    end else begin
                        m_idx++;
                    end
                end
            end else begin
                m_cnt++;
            end
            popped = 0;
            if (rd_pop && m_q.size() > 0) begin
                void'(m_q.pop_front());
                popped = 1;
            end
            if (fin) begin
                if (m_q.size() < 2) m_q.push_back(w);
                else m_ovr = 1;
            end else if (!cont_en) begin
                m_ovr = 0;
            end
            if (fin) m_single = 0;
            if (single_req) m_single = 1;
            if (popped) begin end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            chk(sclk_out == (m_phase ^ clk_inv), "R5/R6 sclk_out", sclk_out, m_phase ^ clk_inv);
            chk(single_busy == m_single, "R3 single_busy", single_busy, m_single);
            chk(rx_ready == (m_q.size() > 0), "R2 rx_ready", rx_ready, m_q.size() > 0);
            chk(overrun == m_ovr, "R9 overrun", overrun, m_ovr);
            chk(irq == ((m_q.size() > 0) && irq_en), "R8 irq", irq, (m_q.size() > 0) && irq_en);
            if (m_q.size() > 0) begin
                chk(rx_data == m_q[0][7:0], "R2 rx_data", rx_data, m_q[0][7:0]);
                chk(rx_bit9 == m_q[0][8], "R7 rx_bit9", rx_bit9, m_q[0][8]);
            end
        end
    end

    // serial data source
    logic [15:0] lfsr = 16'hACE1;
    always @(negedge clk) begin
        lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        data_in <= lfsr[0];
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++; total++;
            $display("FAIL R1 watchdog actual=%0d expected<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_single();
        @(negedge clk); single_req = 1'b1;
        @(negedge clk); single_req = 1'b0;
    endtask

    task automatic pop_one();
        @(negedge clk); rd_pop = 1'b1;
        @(negedge clk); rd_pop = 1'b0;
    endtask

    initial begin
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        // reset state
        chk(rx_ready == 0, "R2 reset rx_ready", rx_ready, 0);
        chk(sclk_out == 0, "R6 reset sclk idle", sclk_out, 0);
        chk(overrun == 0, "R9 reset overrun", overrun, 0);

        // single 8-bit word, div 1, high byte ignored (R10)
        port_en = 1; sync_master = 1; div_lo = 8'd1; div_hi = 8'hFF; div_wide = 0;
        pulse_single();
        wait_n(8 * 4 + 10);
        chk(single_busy == 0, "R3 single clears", single_busy, 0);
        chk(rx_ready == 1, "R10 word after narrow divider", rx_ready, 1);
        pop_one();
        chk(rx_ready == 0, "R2 pop empties", rx_ready, 0);

        // 9-bit, inverted clock, divider 0, interrupt enabled
        rx9_en = 1; clk_inv = 1; div_lo = 8'd0; irq_en = 1;
        wait_n(2);
        chk(sclk_out == 1, "R6 idle high", sclk_out, 1);
        pulse_single();
        wait_n(9 * 2 + 6);
        chk(irq == 1, "R8 irq with enable", irq, 1);
        chk(rx_bit9 == m_q[0][8], "R7 ninth bit", rx_bit9, m_q[0][8]);
        pop_one();
        irq_en = 0; clk_inv = 0; rx9_en = 0;

        // port disabled: request waits (R1)
        port_en = 0; div_lo = 8'd1;
        pulse_single();
        wait_n(100);
        chk(rx_ready == 0, "R1 no word while disabled", rx_ready, 0);
        chk(sclk_out == 0, "R1 clock held idle", sclk_out, 0);
        port_en = 1;
        wait_n(8 * 4 + 10);
        chk(rx_ready == 1, "R1 starts once enabled", rx_ready, 1);
        pop_one();

        // continuous with host keeping up, then abort mid-word (R4, R1)
        div_lo = 8'd2; cont_en = 1;
        for (int i = 0; i < 8 * 6 * 5; i++) begin
            @(negedge clk); rd_pop = rx_ready;
        end
        @(negedge clk); rd_pop = 0;
        wait_n(7);
        cont_en = 0;
        wait_n(2);
        chk(sclk_out == 0, "R1 abort returns idle", sclk_out, 0);
        while (rx_ready) pop_one();

        // both enables, no reads -> overrun (R4, R9)
        div_lo = 8'd1; cont_en = 1;
        pulse_single();
        wait_n(8 * 4 * 2 + 4);
        chk(single_busy == 0, "R4 single cleared under continuous", single_busy, 0);
        chk(rx_ready == 1, "R4 reception continues", rx_ready, 1);
        wait_n(8 * 4 + 4);
        chk(overrun == 1, "R9 overrun raised", overrun, 1);
        wait_n(20);
        chk(sclk_out == 0, "R9 clock halted", sclk_out, 0);
        cont_en = 0;
        wait_n(1);
        chk(overrun == 0, "R9 cleared by dropping cont", overrun, 0);
        pop_one(); pop_one();
        chk(rx_ready == 0, "R2 two words held", rx_ready, 0);

        // 16-bit divider (R10)
        div_wide = 1; div_hi = 8'd1; div_lo = 8'd0;
        pulse_single();
        wait_n(8 * 514 - 20);
        chk(rx_ready == 0, "R10 wide divider slow", rx_ready, 0);
        wait_n(40);
        chk(rx_ready == 1, "R10 wide divider word", rx_ready, 1);
        pop_one();

        wait_n(5);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule